// File: doc/BRIEF.md
# Video Scaling Step Calculator

This block turns a requested resize into the fixed-point step values that a horizontal or vertical video scaler is loaded with. A caller presents a source size, a destination size, the axis and a reduction mode, and pulses a start strobe. The block first pre-scales the source by the reduction mode's factor. It then divides that effective source, moved up by 21 fraction bits, by the destination size, and rounds the quotient up. This gives the master step. From the master step it derives the luma and chroma step values and two companion values. It also reports the pre-divider code that the scaler's output stage has to use with that step.

The divide is a restoring division that produces one quotient bit per clock. The block holds busy high while it works and pulses done once all outputs are valid. A destination size of zero is rejected with an error flag and never starts a divide. A start strobe that arrives while a divide is running is dropped.

Top module: `scs_step_calc`

## Requirements
- R1: When done pulses, `step` equals ceil(E * 2^21 / D). D is `dst_size` and E is the effective source taken from R3. The value is 37 bits wide.
- R2: The quotient is rounded up. A nonzero remainder adds one to the truncated quotient, and an exact division is not incremented.
- R3: `mode` encoding: 0 = enlarge (E = src, `div_code` 00), 1 = half (E = src>>1, code 01), 2 = quarter (E = src>>2, code 10), 3 = treated as enlarge (E = src, code 00).
- R4: With `axis_vert` = 0, `luma_step` and `chroma_step` equal step>>2, and `aux_a` and `aux_b` equal step>>1.
- R5: With `axis_vert` = 1, `luma_step` = step>>2 and `aux_a` = luma_step + 0x514. `chroma_step` = step>>2 in modes 0 and 3 and step>>3 in modes 1 and 2, and `aux_b` = chroma_step + 0x514.
- R6: `busy` rises in the cycle after an accepted start. `done` is a one-cycle pulse 38 clocks after the start edge, and `busy` falls in the same cycle. The result outputs hold until the next completion.
- R7: A start with `dst_size` = 0 sets `err` in the next cycle. It raises neither `busy` nor `done` and leaves the result outputs unchanged. The next accepted start with a nonzero `dst_size` clears `err`.
- R8: A start pulse while `busy` is high is ignored. The running calculation finishes on its own schedule with its own inputs.
- R9: Synchronous reset clears `busy`, `done`, `err` and all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled when idle |
| axis_vert | input | 1 | 0 = horizontal derived set, 1 = vertical derived set |
| mode | input | 2 | Reduction mode (R3) |
| src_size | input | 16 | Source width or height in pixels |
| dst_size | input | 16 | Destination width or height in pixels |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start had a zero destination |
| step | output | 37 | Master step, rounded up |
| luma_step | output | 37 | Luma step value |
| chroma_step | output | 37 | Chroma step value |
| aux_a | output | 37 | First companion value |
| aux_b | output | 37 | Second companion value |
| div_code | output | 2 | Pre-divider code for the output stage |

## Verification
The bench builds the block with its default widths: 16-bit sizes and 21 fraction bits. At these widths the 38-cycle latency, the full 37-bit quotient for a destination of 1 and the largest source, and the truncation of odd sources in half and quarter modes can all be reached directly. Its vectors cover exact and inexact divisions on both axes and in every mode, including the reserved one. It also drives a zero effective source, a zero destination and a start strobe that arrives in the middle of a run.

// File: rtl/scs_pkg.sv
package scs_pkg;

    typedef enum logic [1:0] {
        MODE_FULL    = 2'd0,
        MODE_HALF    = 2'd1,
        MODE_QUARTER = 2'd2,
        MODE_RSVD    = 2'd3
    } scale_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } calc_state_e;

    typedef struct packed {
        logic        vert;
        scale_mode_e mode;
    } req_cfg_t;

    localparam logic [11:0] VERT_BIAS = 12'h514;

    // pre-divider code reported to the scaler output stage
    function automatic logic [1:0] prediv_code(scale_mode_e m);
        case (m)
            MODE_HALF:    return 2'b01;
            MODE_QUARTER: return 2'b10;
            default:      return 2'b00;
        endcase
    endfunction

    // right shift applied to the source before dividing
    function automatic logic [1:0] src_shift(scale_mode_e m);
        case (m)
            MODE_HALF:    return 2'd1;
            MODE_QUARTER: return 2'd2;
            default:      return 2'd0;
        endcase
    endfunction

    function automatic logic is_reduce(scale_mode_e m);
        return (m == MODE_HALF) || (m == MODE_QUARTER);
    endfunction

endpackage

// File: rtl/scs_restoring_div.sv
module scs_restoring_div #(
    parameter int NUM_W = 37,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [NUM_W-1:0] quot,
    output logic             rem_nz
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] acc_q;   // numerator bits shift out, quotient bits shift in
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             fin_q;

    logic [DEN_W:0]   shifted;
    logic             fits;
    logic [DEN_W:0]   diff;

    always_comb begin
        shifted = {rem_q, acc_q[NUM_W-1]};
        fits    = shifted >= {1'b0, den_q};
        diff    = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load && !run_q) begin
                acc_q <= num;
                rem_q <= '0;
                den_q <= den;
                cnt_q <= CNT_W'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                acc_q <= {acc_q[NUM_W-2:0], fits};
                rem_q <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin    = fin_q;
    assign quot   = acc_q;
    assign rem_nz = |rem_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (rem_q < den_q)); // R1
    AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fin_q |=> !fin_q); // R6

endmodule

// File: rtl/scs_derive.sv
module scs_derive
    import scs_pkg::*;
#(
    parameter int STEP_W = 37
) (
    input  logic [STEP_W-1:0] quot,
    input  logic              round_up,
    input  logic              vert,
    input  logic              reduce,
    output logic [STEP_W-1:0] master,
    output logic [STEP_W-1:0] luma,
    output logic [STEP_W-1:0] chroma,
    output logic [STEP_W-1:0] aux_a,
    output logic [STEP_W-1:0] aux_b
);
    localparam logic [STEP_W-1:0] BIAS = STEP_W'(VERT_BIAS);

    always_comb begin
        master = quot + STEP_W'(round_up);
        luma   = master >> 2;
        if (vert) begin
            chroma = reduce ? (master >> 3) : (master >> 2);
            aux_a  = luma + BIAS;
            aux_b  = chroma + BIAS;
        end else begin
            chroma = master >> 2;
            aux_a  = master >> 1;
            aux_b  = master >> 1;
        end
    end

endmodule

// File: rtl/scs_step_calc.sv
module scs_step_calc
    import scs_pkg::*;
#(
    parameter int SIZE_W = 16,
    parameter int FRAC_W = 21,
    localparam int STEP_W = SIZE_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              axis_vert,
    input  logic [1:0]        mode,
    input  logic [SIZE_W-1:0] src_size,
    input  logic [SIZE_W-1:0] dst_size,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [STEP_W-1:0] step,
    output logic [STEP_W-1:0] luma_step,
    output logic [STEP_W-1:0] chroma_step,
    output logic [STEP_W-1:0] aux_a,
    output logic [STEP_W-1:0] aux_b,
    output logic [1:0]        div_code
);
    calc_state_e state_q;
    req_cfg_t    cfg_q;
    scale_mode_e req_mode;
    logic        accept;
    logic        go;
    logic [SIZE_W-1:0] eff_src;
    logic [STEP_W-1:0] numer;

    logic              div_fin;
    logic [STEP_W-1:0] div_quot;
    logic              div_rem_nz;

    logic [STEP_W-1:0] d_master, d_luma, d_chroma, d_aux_a, d_aux_b;

    always_comb begin
        req_mode = scale_mode_e'(mode);
        accept   = start && (state_q == ST_IDLE);
        go       = accept && (dst_size != '0);
        eff_src  = src_size >> src_shift(req_mode);
        numer    = {eff_src, {FRAC_W{1'b0}}};
    end

    scs_restoring_div #(
        .NUM_W(STEP_W),
        .DEN_W(SIZE_W)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .load   (go),
        .num    (numer),
        .den    (dst_size),
        .fin    (div_fin),
        .quot   (div_quot),
        .rem_nz (div_rem_nz)
    );

    scs_derive #(
        .STEP_W(STEP_W)
    ) u_derive (
        .quot     (div_quot),
        .round_up (div_rem_nz),
        .vert     (cfg_q.vert),
        .reduce   (is_reduce(cfg_q.mode)),
        .master   (d_master),
        .luma     (d_luma),
        .chroma   (d_chroma),
        .aux_a    (d_aux_a),
        .aux_b    (d_aux_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cfg_q       <= '0;
            done        <= 1'b0;
            err         <= 1'b0;
            step        <= '0;
            luma_step   <= '0;
            chroma_step <= '0;
            aux_a       <= '0;
            aux_b       <= '0;
            div_code    <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                if (dst_size == '0) begin
                    err <= 1'b1;
                end else begin
                    err     <= 1'b0;
                    cfg_q   <= '{vert: axis_vert, mode: req_mode};
                    state_q <= ST_RUN;
                end
            end else if (state_q == ST_RUN && div_fin) begin
                step        <= d_master;
                luma_step   <= d_luma;
                chroma_step <= d_chroma;
                aux_a       <= d_aux_a;
                aux_b       <= d_aux_b;
                div_code    <= prediv_code(cfg_q.mode);
                done        <= 1'b1;
                state_q     <= ST_IDLE;
            end
        end
    end

    assign busy = (state_q == ST_RUN);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R6
    AST_ZERO_DEST_REJECT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && dst_size == '0) |=> (err && !busy && !done)); // R7
    AST_BUSY_HOLDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
        (busy && !div_fin) |=> (busy && $stable(cfg_q))); // R8
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (div_code != 2'b11)); // R3

endmodule

// File: tb/tb_scs_step_calc.sv
module tb_scs_step_calc;
    localparam int SW = 16;
    localparam int FW = 21;
    localparam int QW = SW + FW;
    localparam int NV = 10;

    // {axis_vert, mode[1:0], src[15:0], dst[15:0]}
    localparam logic [34:0] VECS [NV] = '{
        {1'b0, 2'd0, 16'd360,   16'd720},
        {1'b0, 2'd1, 16'd720,   16'd360},
        {1'b0, 2'd2, 16'd721,   16'd100},
        {1'b1, 2'd0, 16'd480,   16'd576},
        {1'b1, 2'd1, 16'd577,   16'd200},
        {1'b1, 2'd2, 16'd1000,  16'd3},
        {1'b0, 2'd3, 16'd300,   16'd7},
        {1'b1, 2'd0, 16'd65535, 16'd1},
        {1'b0, 2'd2, 16'd3,     16'd9},
        {1'b1, 2'd3, 16'd99,    16'd13}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic axis_vert = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [SW-1:0] src_size = '0;
    logic [SW-1:0] dst_size = '0;
    logic busy, done, err;
    logic [QW-1:0] step, luma_step, chroma_step, aux_a, aux_b;
    logic [1:0] div_code;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    scs_step_calc dut (
        .clk(clk), .rst(rst), .start(start), .axis_vert(axis_vert),
        .mode(mode), .src_size(src_size), .dst_size(dst_size),
        .busy(busy), .done(done), .err(err), .step(step),
        .luma_step(luma_step), .chroma_step(chroma_step),
        .aux_a(aux_a), .aux_b(aux_b), .div_code(div_code)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [QW-1:0] ref_step(input logic [1:0] m, input logic [15:0] s,
                                               input logic [15:0] d);
        logic [63:0] e, n, q;
        e = (m == 2'd1) ? 64'(s / 2) : (m == 2'd2) ? 64'(s / 4) : 64'(s);
        n = e * 64'd2097152;
        q = n / 64'(d);
        if ((n % 64'(d)) != 0) q = q + 1;
        return q[QW-1:0];
    endfunction

    task automatic pulse_start(input logic v, input logic [1:0] m,
                               input logic [15:0] s, input logic [15:0] d);
        @(negedge clk);
        start = 1'b1; axis_vert = v; mode = m; src_size = s; dst_size = d;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // called at the negedge right after the start edge
    task automatic finish_and_check(input logic v, input logic [1:0] m,
                                    input logic [15:0] s, input logic [15:0] d,
                                    input bit poke);
        logic [QW-1:0] em, el, ec, ea, eb;
        logic [1:0] ecode;
        bit early;
        bit red;
        early = 0;
        chk("R6 busy after start", 64'(busy), 64'd1);
        for (int i = 1; i <= 37; i++) begin
            @(negedge clk);
            if (done !== 1'b0 || busy !== 1'b1) early = 1;
            if (poke && i == 5) begin
                start = 1'b1; axis_vert = ~v; mode = 2'd1; src_size = 16'd7; dst_size = 16'd0;
            end
            if (poke && i == 6) start = 1'b0;
        end
        chk("R6 no early done", 64'(early), 64'd0);
        @(negedge clk);
        chk("R6 done at cycle 38", 64'(done), 64'd1);
        chk("R6 busy low at done", 64'(busy), 64'd0);
        red = (m == 2'd1) || (m == 2'd2);
        em = ref_step(m, s, d);
        el = em >> 2;
        if (v) begin
            ec = red ? (em >> 3) : (em >> 2);
            ea = el + QW'(12'h514);
            eb = ec + QW'(12'h514);
        end else begin
            ec = em >> 2;
            ea = em >> 1;
            eb = em >> 1;
        end
        ecode = (m == 2'd1) ? 2'b01 : (m == 2'd2) ? 2'b10 : 2'b00;
        chk("R1 R2 step", 64'(step), 64'(em));
        chk("R3 div_code", 64'(div_code), 64'(ecode));
        if (v) begin
            chk("R5 luma", 64'(luma_step), 64'(el));
            chk("R5 chroma", 64'(chroma_step), 64'(ec));
            chk("R5 aux_a", 64'(aux_a), 64'(ea));
            chk("R5 aux_b", 64'(aux_b), 64'(eb));
        end else begin
            chk("R4 luma", 64'(luma_step), 64'(el));
            chk("R4 chroma", 64'(chroma_step), 64'(ec));
            chk("R4 aux_a", 64'(aux_a), 64'(ea));
            chk("R4 aux_b", 64'(aux_b), 64'(eb));
        end
        if (poke) chk("R8 err untouched by ignored start", 64'(err), 64'd0);
        @(negedge clk);
        chk("R6 done one cycle", 64'(done), 64'd0);
        chk("R6 step held", 64'(step), 64'(em));
    endtask

    initial begin
        logic [QW-1:0] held;
        bit saw;
        repeat (3) @(negedge clk);
        chk("R9 busy reset", 64'(busy), 64'd0);
        chk("R9 done reset", 64'(done), 64'd0);
        chk("R9 err reset", 64'(err), 64'd0);
        chk("R9 outputs reset", 64'(step | luma_step | chroma_step | aux_a | aux_b), 64'd0);
        chk("R9 code reset", 64'(div_code), 64'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            pulse_start(VECS[k][34], VECS[k][33:32], VECS[k][31:16], VECS[k][15:0]);
            finish_and_check(VECS[k][34], VECS[k][33:32], VECS[k][31:16], VECS[k][15:0], 0);
        end

        // exact division: no increment
        pulse_start(1'b0, 2'd0, 16'd100, 16'd25);
        finish_and_check(1'b0, 2'd0, 16'd100, 16'd25, 0);
        chk("R2 exact not bumped", 64'(step), 64'd8388608);

        // zero destination
        held = step;
        pulse_start(1'b1, 2'd1, 16'd640, 16'd0);
        chk("R7 err set", 64'(err), 64'd1);
        chk("R7 no busy", 64'(busy), 64'd0);
        saw = 0;
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            if (done || busy) saw = 1;
        end
        chk("R7 no done or busy", 64'(saw), 64'd0);
        chk("R7 outputs kept", 64'(step), 64'(held));
        pulse_start(1'b1, 2'd2, 16'd800, 16'd50);
        chk("R7 err cleared", 64'(err), 64'd0);
        finish_and_check(1'b1, 2'd2, 16'd800, 16'd50, 0);

        // start while busy
        pulse_start(1'b0, 2'd1, 16'd1920, 16'd1000);
        finish_and_check(1'b0, 2'd1, 16'd1920, 16'd1000, 1);
        chk("R8 still idle after ignored start", 64'(busy), 64'd0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule